// File: doc/BRIEF.md
# Boundary-Framed Word Serializer

This block turns parallel words into a single serial bit stream with a companion bit clock. A word on `din` is taken on each rising edge of `strobe`. It is padded with two zero bits, and two boundary bits that depend on the last padded bit are added after it. The resulting 26-bit frame is sent one bit per bit slot, least significant input bit first. The framing is carried by the clock itself: in the slot of the first boundary bit the bit clock leaves out its low half. A receiver finds the word edge from that missing pulse and from the data transition that the boundary bits always produce.

The block runs on a core clock at twice the bit rate, so one bit slot is two core cycles. `phase_en` is the advance enable that comes from the reference divider. A core cycle with `phase_en` low does not move the slot timing. When the reference runs faster than the strobe, slots with no word to send carry zero data while the clock keeps toggling normally. A word strobed while a frame is in flight waits in a one-word holding register and goes out directly after the current frame. `enable` low, like reset, parks the lines and drops all state.

Top module: `bndry_serializer`

## Requirements
- R1: A frame is 26 slots. Slots 1 to 22 carry `din[0]` to `din[21]` in that order, and slots 23 and 24 carry 0.
- R2: Slot 25 carries the inverse of slot 24 and slot 26 carries the value of slot 24. With the zero padding this is 1 then 0.
- R3: A word is taken from `din` in the core cycle in which `strobe` is seen going from 0 to 1. A strobe held high, or a falling strobe, takes no further word.
- R4: Each slot spans two advancing core cycles. `bit_clk` is 1 in the first half and 0 in the second half, and `ser_data` is the same in both halves.
- R5: In slot 25 of every frame `bit_clk` stays 1 in the second half, so it is high for three half-slots in a row. No other slot skips its low half.
- R6: A slot in which no frame is being sent has `ser_data` 0, with the normal clock pattern.
- R7: A word strobed while a frame is being sent is held, and its frame starts in the slot right after slot 26 of the current frame.
- R8: A further strobe before the held word has started replaces the held word, and the replaced word is never sent.
- R9: In a core cycle with `phase_en` at 0, the slot timing does not advance and both outputs keep their values.
- R10: While `rst_n` is 0 or `enable` is 0, `ser_data` is 0 and `bit_clk` is 1. A frame in flight and a held word are both discarded. After `enable` returns, the next slot starts in its first half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, two cycles per bit slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; 0 parks outputs and clears state |
| phase_en | input | 1 | Half-slot advance enable from the reference divider |
| strobe | input | 1 | Word strobe; its rising edge takes `din` |
| din | input | DATA_W (22) | Parallel input word |
| ser_data | output | 1 | Serial data, aligned to bit_clk edges |
| bit_clk | output | 1 | Bit clock with one low half left out per frame |

## Verification
The bench sends walking-one, walking-zero and arithmetic words and decodes every frame from the line itself, using only the missing low half. A wrong bit order, wrong padding or wrong boundary bits therefore show up as a data mismatch, and a pulse skipped in the wrong slot produces a frame that should not exist. Strobes arriving mid-frame check that a held word follows with no idle slot in between and that a later strobe replaces it. A design that queued more than one word, or lost the held one, would send an extra frame or drop one. A held-high strobe, phase stalls, and disable in the middle of a frame are also covered: a design that re-captured on a level, advanced while stalled, or resumed a discarded word would send extra frames, break data within a slot, or put non-zero bits on idle slots.

// File: rtl/bser_pkg.sv
package bser_pkg;
  typedef enum logic {HALF_HIGH = 1'b0, HALF_LOW = 1'b1} half_e;

  // boundary pair derived from the last padded bit: [0] first boundary slot, [1] second
  function automatic logic [1:0] bnd_bits(input logic last_bit);
    return {last_bit, ~last_bit};
  endfunction
endpackage

// File: rtl/bser_capture.sv
module bser_capture #(
  parameter int unsigned DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic              cap_evt,
  output logic              held_vld,
  output logic [DATA_W-1:0] held_word
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign cap_evt = enable & strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_word <= '0;
    end else if (!enable) begin
      held_vld  <= 1'b0;
    end else if (cap_evt) begin
      held_vld  <= 1'b1;
      held_word <= din;
    end else if (take) begin
      held_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/bser_sequencer.sv
module bser_sequencer
  import bser_pkg::*;
#(
  parameter int unsigned DATA_W  = 22,
  parameter int unsigned PAY_W   = 24,
  localparam int unsigned FRAME_W = PAY_W + 2,
  localparam int unsigned SLOT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               phase_en,
  input  logic               held_vld,
  input  logic [DATA_W-1:0]  held_word,
  output logic               take,
  output logic               load_evt,
  output half_e              half_q,
  output logic               busy_q,
  output logic [SLOT_W-1:0]  slot_q,
  output logic [FRAME_W-1:0] frame_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);

  if (DATA_W > PAY_W) begin : g_bad_width
    $error("DATA_W must not exceed PAY_W");
  end

  function automatic logic [FRAME_W-1:0] make_frame(input logic [DATA_W-1:0] w);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[DATA_W-1:0] = w;
    {f[FRAME_W-1], f[FRAME_W-2]} = bnd_bits(f[PAY_W-1]);
    return f;
  endfunction

  logic adv, slot_end, word_done;

  assign adv       = enable & phase_en;
  assign slot_end  = adv & (half_q == HALF_LOW);
  assign word_done = ~busy_q | (slot_q == LAST_SLOT);
  assign load_evt  = slot_end & word_done & held_vld;
  assign take      = load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= HALF_HIGH;
      busy_q  <= 1'b0;
      slot_q  <= '0;
      frame_q <= '0;
    end else if (!enable) begin
      half_q  <= HALF_HIGH;
      busy_q  <= 1'b0;
      slot_q  <= '0;
    end else if (adv) begin
      half_q <= (half_q == HALF_HIGH) ? HALF_LOW : HALF_HIGH;
      if (half_q == HALF_LOW) begin
        if (word_done) begin
          busy_q <= held_vld;
          slot_q <= '0;
          if (held_vld) frame_q <= make_frame(held_word);
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bser_line.sv
module bser_line
  import bser_pkg::*;
#(
  parameter int unsigned PAY_W   = 24,
  localparam int unsigned FRAME_W = PAY_W + 2,
  localparam int unsigned SLOT_W  = $clog2(FRAME_W)
) (
  input  logic               enable,
  input  half_e              half_q,
  input  logic               busy_q,
  input  logic [SLOT_W-1:0]  slot_q,
  input  logic [FRAME_W-1:0] frame_q,
  output logic               skip_low,
  output logic               ser_data,
  output logic               bit_clk
);
  // slot index PAY_W holds the first boundary bit
  assign skip_low = busy_q & (slot_q == SLOT_W'(PAY_W));
  assign ser_data = enable & busy_q & frame_q[slot_q];
  assign bit_clk  = ~enable | (half_q == HALF_HIGH) | skip_low;
endmodule

// File: rtl/bndry_serializer.sv
module bndry_serializer
  import bser_pkg::*;
#(
  parameter int unsigned DATA_W = 22,
  parameter int unsigned PAY_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              phase_en,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic              ser_data,
  output logic              bit_clk
);
  localparam int unsigned FRAME_W = PAY_W + 2;
  localparam int unsigned SLOT_W  = $clog2(FRAME_W);

  logic               cap_evt, held_vld, take, load_evt, busy_q, skip_low;
  logic [DATA_W-1:0]  held_word;
  half_e              half_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [FRAME_W-1:0] frame_q;

  bser_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .din(din),
    .take(take), .cap_evt(cap_evt), .held_vld(held_vld), .held_word(held_word)
  );

  bser_sequencer #(.DATA_W(DATA_W), .PAY_W(PAY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_en(phase_en),
    .held_vld(held_vld), .held_word(held_word), .take(take), .load_evt(load_evt),
    .half_q(half_q), .busy_q(busy_q), .slot_q(slot_q), .frame_q(frame_q)
  );

  bser_line #(.PAY_W(PAY_W)) u_line (
    .enable(enable), .half_q(half_q), .busy_q(busy_q), .slot_q(slot_q),
    .frame_q(frame_q), .skip_low(skip_low), .ser_data(ser_data), .bit_clk(bit_clk)
  );
endmodule

// File: rtl/bndry_serializer_chk.sv
module bndry_serializer_chk
  import bser_pkg::*;
#(
  parameter int unsigned DATA_W = 22,
  parameter int unsigned PAY_W  = 24,
  localparam int unsigned FRAME_W = PAY_W + 2,
  localparam int unsigned SLOT_W  = $clog2(FRAME_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               phase_en,
  input logic               ser_data,
  input logic               bit_clk,
  input logic               cap_evt,
  input logic               held_vld,
  input logic               load_evt,
  input half_e              half_q,
  input logic               busy_q,
  input logic [SLOT_W-1:0]  slot_q,
  input logic [FRAME_W-1:0] frame_q
);
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (frame_q[PAY_W-1:DATA_W] == '0));

  p_bnd_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (frame_q[PAY_W] == !frame_q[PAY_W-1]) && (frame_q[PAY_W+1] == frame_q[PAY_W-1]));

  p_capture_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (!enable || held_vld));

  p_first_half_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q == HALF_HIGH) |-> bit_clk);

  p_skip_only_bnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && half_q == HALF_LOW && bit_clk) |-> (busy_q && slot_q == SLOT_W'(PAY_W)));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busy_q) |-> !ser_data);

  p_held_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!enable || (busy_q && slot_q == '0)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !phase_en) |=> (!enable || ($stable(half_q) && $stable(slot_q))));

  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!ser_data && bit_clk));
endmodule

bind bndry_serializer bndry_serializer_chk #(.DATA_W(DATA_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .phase_en(phase_en),
  .ser_data(ser_data), .bit_clk(bit_clk), .cap_evt(cap_evt), .held_vld(held_vld),
  .load_evt(load_evt), .half_q(half_q), .busy_q(busy_q), .slot_q(slot_q), .frame_q(frame_q)
);

// File: tb/bndry_serializer_bench.sv
module bndry_serializer_bench;
  localparam int DW   = 22;
  localparam int NS   = 16384;
  localparam logic [DW-1:0] MASK = {DW{1'b1}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, ph = 1'b1, stb = 1'b0;
  logic [DW-1:0] din = '0;
  wire sd, bc;

  bndry_serializer u_bndry_serializer (
    .clk(clk), .rst_n(rst_n), .enable(en), .phase_en(ph), .strobe(stb),
    .din(din), .ser_data(sd), .bit_clk(bc)
  );

  int errors = 0, checks = 0;
  logic [DW-1:0] expq[$];
  logic hist [0:NS-1];
  logic care [0:NS-1];
  logic infr [0:NS-1];
  int fstart [0:1023];
  int fend   [0:1023];
  int nframes = 0, sc = 0, last_end = -1;
  logic tb_half = 1'b0, last_half = 1'b1, prev_skip = 1'b0, d0 = 1'b0;
  logic prev_sd = 1'b0, prev_bc = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin hist[i] = 1'b0; care[i] = 1'b0; infr[i] = 1'b0; end
  end

  // half-slot tracker from R4/R9/R10
  always @(posedge clk) begin
    if (!rst_n || !en) tb_half <= 1'b0;
    else if (ph)       tb_half <= ~tb_half;
  end

  // line monitor and frame decoder
  always @(negedge clk) begin
    int st;
    logic [DW-1:0] w;
    logic [DW-1:0] e;
    if (rst_n) begin
      if (!en) begin
        chk(sd == 1'b0 && bc == 1'b1, "R10 parked lines while disabled", {sd, bc}, 2'b01);
        for (int i = last_end + 1; i < sc; i++) care[i] = 1'b0;
        last_half = 1'b1;
        prev_skip = 1'b0;
      end else if (tb_half == last_half) begin
        chk(sd == prev_sd && bc == prev_bc, "R9 outputs stable during stall", {sd, bc}, {prev_sd, prev_bc});
      end else begin
        last_half = tb_half;
        if (!tb_half) begin
          chk(bc == 1'b1, "R4 clock high in first half", bc, 1);
          d0 = sd;
        end else begin
          chk(sd == d0, "R4 data steady across slot", sd, d0);
          if (sc < NS) begin
            hist[sc] = sd;
            care[sc] = 1'b1;
            chk(!(bc && prev_skip), "R5 low half skipped two slots in a row", bc, 0);
            if (prev_skip && sc >= 25) begin
              st = sc - 25;
              chk(hist[st+22] == 1'b0 && hist[st+23] == 1'b0, "R1 padding slots zero",
                  {hist[st+22], hist[st+23]}, 0);
              chk(hist[st+24] == !hist[st+23] && hist[st+25] == hist[st+23], "R2 boundary bits",
                  {hist[st+24], hist[st+25]}, {!hist[st+23], hist[st+23]});
              for (int i = 0; i < DW; i++) w[i] = hist[st+i];
              if (expq.size() == 0) begin
                chk(1'b0, "R5 frame seen with none expected", w, 0);
              end else begin
                e = expq.pop_front();
                chk(w == e, "R1 frame data", w, e);
              end
              for (int i = st; i <= sc; i++) infr[i] = 1'b1;
              if (nframes < 1024) begin fstart[nframes] = st; fend[nframes] = sc; end
              nframes++;
              last_end = sc;
            end
            prev_skip = bc;
            sc++;
          end
        end
      end
      prev_sd = sd;
      prev_bc = bc;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [DW-1:0] w);
    din = w; stb = 1'b1; tick(2);
    stb = 1'b0; tick(2);
  endtask

  task automatic wait_frames(input int target, input string tag);
    int t = 0;
    while (nframes < target && t < 3000) begin tick(1); t++; end
    chk(nframes >= target, tag, nframes, target);
  endtask

  task automatic one(input logic [DW-1:0] w, input int gap);
    int n0 = nframes;
    expq.push_back(w);
    send(w);
    wait_frames(n0 + 1, "R1 frame arrives");
    tick(gap);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int n0;
    int bad;
    tick(4);
    @(negedge clk);
    chk(sd == 1'b0 && bc == 1'b1, "R10 outputs in reset", {sd, bc}, 2'b01);
    tick(1);
    rst_n = 1'b1;
    tick(3);
    en = 1'b1;
    tick(6);

    // R1/R2 sweep
    for (int k = 0; k < DW; k++) one(DW'(1) << k, k % 4);
    for (int k = 0; k < DW; k++) one(MASK ^ (DW'(1) << k), k % 3);
    one('0, 0); one(MASK, 1); one(22'h155555, 2); one(22'h2AAAAA, 0);
    for (int k = 1; k <= 40; k++) one(DW'((k * 40503) ^ (k << 13)) & MASK, k % 5);

    // R7: word strobed mid-frame follows with no gap
    n0 = nframes;
    expq.push_back(22'h0ABCDE); expq.push_back(22'h31F0F1);
    send(22'h0ABCDE); tick(8); send(22'h31F0F1);
    wait_frames(n0 + 2, "R7 held frame arrives");
    chk(fstart[n0+1] == fend[n0] + 1, "R7 held frame starts right after boundary", fstart[n0+1], fend[n0] + 1);
    tick(10);

    // R8: later strobe replaces held word
    n0 = nframes;
    expq.push_back(22'h112233); expq.push_back(22'h3C3C3C);
    send(22'h112233); tick(6); send(22'h2EEEEE); tick(4); send(22'h3C3C3C);
    wait_frames(n0 + 2, "R8 replacing frame arrives");
    chk(fstart[n0+1] == fend[n0] + 1, "R7 replacing frame follows at once", fstart[n0+1], fend[n0] + 1);
    tick(200);
    chk(nframes == n0 + 2, "R8 replaced word never sent", nframes, n0 + 2);

    // R3: held-high strobe takes one word; din changes after the edge are ignored
    n0 = nframes;
    expq.push_back(22'h2468AC);
    din = 22'h2468AC; stb = 1'b1; tick(3);
    din = 22'h1DB975; tick(300);
    chk(nframes == n0 + 1, "R3 held strobe sends one frame", nframes, n0 + 1);
    stb = 1'b0; tick(200);
    chk(nframes == n0 + 1, "R3 falling strobe takes nothing", nframes, n0 + 1);

    // R9: phase stalls stretch slots
    n0 = nframes;
    fork
      begin
        repeat (400) begin ph = 1'b0; tick(1); ph = 1'b1; tick(2); end
      end
      begin
        for (int k = 0; k < 3; k++) begin
          expq.push_back(22'h0F0F0F ^ DW'(k * 4097));
          send(22'h0F0F0F ^ DW'(k * 4097));
          wait_frames(n0 + k + 1, "R9 frame under stalls");
        end
      end
    join
    tick(10);

    // R10: disable mid-frame drops the frame and the held word
    n0 = nframes;
    send(22'h155AA5); tick(6); send(22'h2A55AA); tick(6);
    en = 1'b0; tick(6);
    en = 1'b1; tick(200);
    chk(nframes == n0, "R10 no frame resumes after disable", nframes, n0);
    expq.push_back(22'h3FFFFE);
    send(22'h3FFFFE);
    wait_frames(n0 + 1, "R10 new frame after re-enable");
    tick(60);

    chk(expq.size() == 0, "R1 all expected frames seen", expq.size(), 0);
    bad = 0;
    for (int i = 0; i < sc; i++) if (care[i] && !infr[i] && hist[i]) bad++;
    chk(bad == 0, "R6 idle slots carry zero", bad, 0);

    summary();
    $finish;
  end
endmodule